// File: doc/BRIEF.md
# Real-Time Clock Timer and Alarm Interrupt Controller

This block produces the interrupt of a real-time clock. It has a fixed-cycle down-counter that runs from one of several external tick sources. It also has an alarm-match strobe from the calendar logic. Each source sets its own sticky flag, and each flag is gated by its own enable onto one shared active-low interrupt pin. The timer can work in two ways. In one-shot mode the interrupt is a level that stays until software clears the timer flag. In periodic mode each timer expiry gives a low pulse that lasts one tick period.

Software reaches three registers through a plain byte-wide port: a control/status register, a timer-setting register and the live down-counter. Writes take effect on the clock edge where `wr_en` is high. The read data depends combinationally on `reg_addr`. Calendar counting, clock-output generation and the serial host bus sit outside this block.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is high.
- R2: Address 0x1 reads {3'b000, periodic, alarm_flag, timer_flag, alarm_en, timer_en}, with timer_en at bit 0 and periodic at bit 4. Address 0xE reads {run, 5'b0, src_sel[1:0]}. Address 0xF reads the live count. Any other address reads 0.
- R3: Writing 0xF loads both the count and the reload value. Each qualified tick lowers a count above 1 by one. A qualified tick at count 1 raises a timer event, sets timer_flag and reloads the count from the last value written to 0xF.
- R4: A tick is qualified only when run (0xE bit 7) is 1 and it arrives on the input selected by src_sel. Any other tick leaves the count unchanged.
- R5: Writing 0 to a flag bit of 0x1 clears that flag. Writing 1 leaves it unchanged, so a write never sets a flag. A flag-setting event in the same cycle as a write takes priority over the clear.
- R6: A cycle with `alarm_hit` high sets alarm_flag, whether or not alarm_en is set.
- R7: Outside a periodic pulse, `irq_n` is high whenever (alarm_flag AND alarm_en) is 0 and (timer_flag AND timer_en) is 0.
- R8: In one-shot mode (periodic = 0) with timer_en set, `irq_n` stays low while timer_flag is 1, across further ticks, until software clears the flag.
- R9: In periodic mode with timer_en set, a timer event drives `irq_n` low until the next qualified tick. After that tick `irq_n` returns high even though timer_flag stays set.
- R10: A count of 0 is disarmed. Qualified ticks leave it at 0 and raise no timer event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| src_tick | input | 4 | Timer source tick strobes, one per source |
| alarm_hit | input | 1 | Alarm-match strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume the following about the inputs: every input is synchronous to `clk`, `reg_addr` and `wr_data` are known whenever `wr_en` is high, and reset is low at time zero. They do not assume that ticks or alarm strobes are one cycle wide, or that they are separated from register writes. The stimulus changes every input on the falling edge and drives each tick, alarm and write as a one-cycle strobe. It then samples the read data and the interrupt pin half a cycle after the edge that consumed the strobe.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h1;
  localparam logic [ADDR_W-1:0] A_TSET = 4'hE;
  localparam logic [ADDR_W-1:0] A_TCNT = 4'hF;
  localparam int TSET_RUN_BIT = 7;

  // packed: periodic is bit 4, timer_en is bit 0
  typedef struct packed {
    logic periodic;
    logic alarm_flag;
    logic timer_flag;
    logic alarm_en;
    logic timer_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_tick_sel.sv
module rtc_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
  end

  assign tick = run && (|hit);
endmodule

// File: rtl/rtc_down_timer.sv
module rtc_down_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;

  assign expire = tick && !load && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt      <= load_val;
      reload_q <= load_val;
    end else if (tick) begin
      if (cnt == ONE)      cnt <= reload_q;
      else if (cnt != '0)  cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_we,
  input  ctrl_t ctrl_wr,
  input  logic  expire,
  input  logic  alarm_hit,
  input  logic  tick,
  output ctrl_t ctrl_q,
  output logic  irq_n
);
  ctrl_t ctrl_d;
  logic  pulse_q, pulse_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.periodic   = ctrl_wr.periodic;
      ctrl_d.alarm_en   = ctrl_wr.alarm_en;
      ctrl_d.timer_en   = ctrl_wr.timer_en;
      ctrl_d.alarm_flag = ctrl_q.alarm_flag & ctrl_wr.alarm_flag;
      ctrl_d.timer_flag = ctrl_q.timer_flag & ctrl_wr.timer_flag;
    end
    if (expire)    ctrl_d.timer_flag = 1'b1;
    if (alarm_hit) ctrl_d.alarm_flag = 1'b1;
  end

  always_comb begin
    if (!ctrl_d.periodic) pulse_d = 1'b0;
    else if (expire)      pulse_d = 1'b1;
    else if (tick)        pulse_d = 1'b0;
    else                  pulse_d = pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      pulse_q <= pulse_d;
    end
  end

  logic alarm_req, timer_req;
  assign alarm_req = ctrl_q.alarm_flag & ctrl_q.alarm_en;
  assign timer_req = ctrl_q.timer_en &
                     (ctrl_q.periodic ? pulse_q : ctrl_q.timer_flag);
  assign irq_n = !(alarm_req | timer_req);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int CNT_W = 8,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_SRC-1:0]  src_tick,
  input  logic              alarm_hit,
  output logic              irq_n
);
  logic             ctrl_we, tset_we, cnt_we;
  logic             run_q;
  logic [SEL_W-1:0] sel_q;
  logic             tick_w, expire_w;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl_q;

  assign ctrl_we = wr_en && (reg_addr == A_CTRL);
  assign tset_we = wr_en && (reg_addr == A_TSET);
  assign cnt_we  = wr_en && (reg_addr == A_TCNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else if (tset_we) begin
      run_q <= wr_data[TSET_RUN_BIT];
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  rtc_tick_sel #(.N_SRC(N_SRC)) u_sel (
    .src_tick (src_tick),
    .sel      (sel_q),
    .run      (run_q),
    .tick     (tick_w)
  );

  rtc_down_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .load     (cnt_we),
    .load_val (wr_data[CNT_W-1:0]),
    .cnt      (cnt_q),
    .expire   (expire_w)
  );

  rtc_irq_flags u_flg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_wr   (ctrl_t'(wr_data[$bits(ctrl_t)-1:0])),
    .expire    (expire_w),
    .alarm_hit (alarm_hit),
    .tick      (tick_w),
    .ctrl_q    (ctrl_q),
    .irq_n     (irq_n)
  );

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      A_CTRL: rd_data[$bits(ctrl_t)-1:0] = ctrl_q;
      A_TSET: begin
        rd_data[TSET_RUN_BIT] = run_q;
        rd_data[SEL_W-1:0]    = sel_q;
      end
      A_TCNT: rd_data[CNT_W-1:0] = cnt_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_we,
  input logic             ctrl_we,
  input logic [7:0]       wr_data,
  input logic             alarm_hit,
  input logic [CNT_W-1:0] cnt,
  input logic [4:0]       ctrl,
  input logic             irq_n
);
  // ctrl: [4] periodic [3] alarm_flag [2] timer_flag [1] alarm_en [0] timer_en
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt > CNT_W'(1)) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

  assert_expire_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt == CNT_W'(1)) |=> ctrl[2]);

  assert_count_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && !(ctrl_we && !wr_data[2])) |=> ctrl[2]);

  assert_alarm_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> ctrl[3]);

  assert_quiet_when_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[1] && !ctrl[0]) |-> irq_n);

  assert_disarmed_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !cnt_we) |=> (cnt == '0));
endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .cnt_we    (cnt_we),
  .ctrl_we   (ctrl_we),
  .wr_data   (wr_data),
  .alarm_hit (alarm_hit),
  .cnt       (cnt_q),
  .ctrl      (ctrl_q),
  .irq_n     (irq_n)
);

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] src_tick = '0;
  logic       alarm_hit = 1'b0;
  logic       irq_n;

  always #5 clk = ~clk;

  rtc_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .src_tick(src_tick),
    .alarm_hit(alarm_hit), .irq_n(irq_n)
  );

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp_data;
    logic       exp_irq;
    string      tag;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;

  // monitor: pops the expected item and compares it with the ports
  always @(sample_ev) begin
    item_t it;
    it = q.pop_front();
    vectors++;
    if (rd_data !== it.exp_data || irq_n !== it.exp_irq) begin
      miscompares++;
      $display("FAIL %s: addr %h rd_data %h irq_n %b, expected %h %b",
               it.tag, it.addr, rd_data, irq_n, it.exp_data, it.exp_irq);
    end
  end

  task automatic look(input logic [3:0] a, input logic [7:0] d,
                      input logic irq, input string tag);
    item_t it;
    reg_addr = a;
    it.addr = a; it.exp_data = d; it.exp_irq = irq; it.tag = tag;
    q.push_back(it);
    #1 -> sample_ev;
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int i);
    @(negedge clk); src_tick[i] = 1'b1;
    @(negedge clk); src_tick = '0;
  endtask

  task automatic alarm();
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look(4'h1, 8'h00, 1'b1, "R1 ctrl reset");
    look(4'hE, 8'h00, 1'b1, "R1 tset reset");
    look(4'hF, 8'h00, 1'b1, "R1 count reset");

    wr(4'hE, 8'h81);
    look(4'hE, 8'h81, 1'b1, "R2 tset readback");
    wr(4'hF, 8'h03);
    look(4'hF, 8'h03, 1'b1, "R3 count load");
    look(4'h5, 8'h00, 1'b1, "R2 unmapped reads 0");

    tick(0);
    look(4'hF, 8'h03, 1'b1, "R4 unselected tick");
    tick(1);
    look(4'hF, 8'h02, 1'b1, "R3 decrement");
    tick(1);
    look(4'hF, 8'h01, 1'b1, "R3 decrement to 1");
    tick(1);
    look(4'h1, 8'h04, 1'b1, "R7 timer flag set, enable off");
    look(4'hF, 8'h03, 1'b1, "R3 reload");

    wr(4'h1, 8'h05);
    look(4'h1, 8'h05, 1'b0, "R8 one-shot level");
    tick(1);
    look(4'h1, 8'h05, 1'b0, "R8 level held across tick");
    wr(4'h1, 8'h01);
    look(4'h1, 8'h01, 1'b1, "R5 clear timer flag");
    wr(4'h1, 8'h0D);
    look(4'h1, 8'h01, 1'b1, "R5 write 1 does not set");

    alarm();
    look(4'h1, 8'h09, 1'b1, "R6 alarm flag, enable off");
    wr(4'h1, 8'h0B);
    look(4'h1, 8'h0B, 1'b0, "R7 alarm enabled asserts");
    wr(4'h1, 8'h03);
    look(4'h1, 8'h03, 1'b1, "R5 clear alarm flag");

    wr(4'h1, 8'h13);
    tick(1);
    look(4'hF, 8'h01, 1'b1, "R3 periodic count");
    tick(1);
    look(4'h1, 8'h17, 1'b0, "R9 periodic pulse low");
    tick(1);
    look(4'h1, 8'h17, 1'b1, "R9 pulse ends, flag kept");
    look(4'hF, 8'h02, 1'b1, "R3 periodic reload");

    wr(4'hE, 8'h01);
    tick(1);
    look(4'hF, 8'h02, 1'b1, "R4 run off holds count");

    wr(4'hF, 8'h00);
    wr(4'h1, 8'h13);
    wr(4'hE, 8'h81);
    tick(1);
    tick(1);
    look(4'hF, 8'h00, 1'b1, "R10 zero stays zero");
    look(4'h1, 8'h13, 1'b1, "R10 no event at zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule